// File: doc/BRIEF.md
# PCI Target Address Parity Checker

This block sits beside the address decoder of a PCI target. Whenever the device is not driving the bus as master, it watches each new transaction. It captures the address and command lines in the clock where FRAME# is first seen low. It then checks them, together with the PAR line presented one clock later, for even parity. A mismatch always sets a sticky "parity error detected" status bit.

When the configuration space has enabled both system-error reporting and parity-error response, three more things happen. The block pulses the SERR# open-drain enable low for a single clock, sets a sticky "system error signalled" status bit, and raises a suppress signal. That signal tells the target's DEVSEL# logic not to claim the corrupted transaction. The suppress signal holds until the bus returns to idle. Software clears either status bit by writing a one to it.

Top module: `pci_addr_par_chk`

## Requirements
- R1: After reset, `serr_oe_n` is 1, and `devsel_suppress`, `sts_det_perr` and `sts_sig_serr` are 0.
- R2: Parity is even. The XOR of `ad[31:0]`, `cbe_n[3:0]` (both taken in the address phase) and `par` (taken on the next clock) must be 0. A result of 1 is an address parity error.
- R3: The address phase is the clock where `frame_n` is sampled 0 after being sampled 1. Later clocks with `frame_n` still 0 are not checked, whatever their parity.
- R4: No check is made for an address phase sampled while `is_master` is 1.
- R5: An address parity error sets `sts_det_perr` at the clock edge that samples `par`, whatever the enables are.
- R6: `serr_oe_n` goes low only when both `cmd_serr_en` (command bit 8) and `cmd_par_resp_en` (command bit 6) are 1 at that edge. It stays low for exactly one clock.
- R7: `serr_oe_n` is low in the second clock after the address phase clock, and is 1 in every other clock.
- R8: `sts_sig_serr` is set in the same clock in which `serr_oe_n` goes low.
- R9: A 1 on `sts_clr_det` or `sts_clr_sig` (status bit 15 or bit 14 written with 1) clears that bit. Without the strobe, the bit holds its value.
- R10: If a set event and a clear strobe for the same bit fall in one clock, the bit ends up 1.
- R11: With both enables at 1 and bad address parity, `devsel_suppress` rises in the same clock as the `serr_oe_n` pulse. It stays 1 until an edge samples both `frame_n` and `irdy_n` at 1. It is never raised when reporting is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | FRAME# as sampled from the bus |
| irdy_n | input | 1 | IRDY# as sampled from the bus |
| ad | input | 32 | Address/data lines |
| cbe_n | input | 4 | Command/byte-enable lines |
| par | input | 1 | Even parity line, valid one clock after the phase it covers |
| is_master | input | 1 | 1 while this device owns the bus as master |
| cmd_serr_en | input | 1 | Command register bit 8, system-error enable |
| cmd_par_resp_en | input | 1 | Command register bit 6, parity-error response enable |
| sts_clr_det | input | 1 | Write-one-to-clear strobe for status bit 15 |
| sts_clr_sig | input | 1 | Write-one-to-clear strobe for status bit 14 |
| serr_oe_n | output | 1 | Active-low enable of the SERR# open-drain driver |
| devsel_suppress | output | 1 | Blocks DEVSEL# for the current transaction |
| sts_det_perr | output | 1 | Status bit 15, detected parity error |
| sts_sig_serr | output | 1 | Status bit 14, signalled system error |

## Verification
Counting edges from the address phase edge E0: `sts_det_perr`, `sts_sig_serr`, `devsel_suppress` and the low `serr_oe_n` all become visible just after E1, which is the edge that samples PAR. `serr_oe_n` returns to 1 after E2. The clear of `devsel_suppress` shows up after the first edge that sees the bus idle. The bench drives every input on the falling clock edge. It samples outputs on the falling edge that follows the edge named above, and once more a clock later, to confirm that a pulse has ended or a value has held. The same approach covers the ignored cases: master-owned cycles, continued FRAME# clocks, and clear strobes. In each of these the bench reads the status and SERR# outputs one falling edge after the edge where a change could have occurred.

// File: rtl/pci_apc_pkg.sv
package pci_apc_pkg;

    typedef struct packed {
        logic frame_prev;
        logic chk;
    } cap_ctl_t;

    typedef struct packed {
        logic det;
        logic sig;
    } apc_sts_t;

    typedef struct packed {
        logic serr_n;
        logic suppress;
    } apc_rsp_t;

endpackage

// File: rtl/pci_apc_capture.sv
module pci_apc_capture #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n,
    input  logic            is_master,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe_n,
    output logic            addr_phase,
    output logic            chk_q,
    output logic [AD_W-1:0] ad_q,
    output logic [BE_W-1:0] cbe_q
);
    import pci_apc_pkg::*;

    cap_ctl_t        ctl_d, ctl_q;
    logic [AD_W-1:0] ad_d;
    logic [BE_W-1:0] cbe_d;

    always_comb begin
        addr_phase      = !frame_n && ctl_q.frame_prev;
        ctl_d.frame_prev = frame_n;
        ctl_d.chk       = addr_phase && !is_master;
        ad_d            = addr_phase ? ad    : ad_q;
        cbe_d           = addr_phase ? cbe_n : cbe_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{frame_prev: 1'b1, chk: 1'b0};
            ad_q  <= '0;
            cbe_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            ad_q  <= ad_d;
            cbe_q <= cbe_d;
        end
    end

    assign chk_q = ctl_q.chk;

    AST_CHECK_ONCE_PER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q |=> !chk_q); // R3

endmodule

// File: rtl/pci_apc_parity.sv
module pci_apc_parity #(
    parameter int AD_W  = 32,
    parameter int BE_W  = 4,
    parameter int LANES = 4
) (
    input  logic            chk_q,
    input  logic [AD_W-1:0] ad_q,
    input  logic [BE_W-1:0] cbe_q,
    input  logic            par,
    output logic            par_err
);
    localparam int LANE_W = AD_W / LANES;

    logic [LANES-1:0] lane_x;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_x[g] = ^ad_q[g*LANE_W +: LANE_W];
    end

    always_comb begin
        par_err = chk_q && ((^lane_x) ^ (^cbe_q) ^ par);
    end

endmodule

// File: rtl/pci_apc_status.sv
module pci_apc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_det,
    input  logic set_sig,
    input  logic clr_det,
    input  logic clr_sig,
    output logic det_q,
    output logic sig_q
);
    import pci_apc_pkg::*;

    apc_sts_t sts_d, sts_q;

    always_comb begin
        sts_d = sts_q;
        if (clr_det) sts_d.det = 1'b0;
        if (clr_sig) sts_d.sig = 1'b0;
        if (set_det) sts_d.det = 1'b1;
        if (set_sig) sts_d.sig = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign det_q = sts_q.det;
    assign sig_q = sts_q.sig;

    AST_DET_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (det_q && !clr_det) |=> det_q); // R9
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (set_det && clr_det) |=> det_q); // R10

endmodule

// File: rtl/pci_addr_par_chk.sv
module pci_addr_par_chk #(
    parameter int AD_W  = 32,
    parameter int BE_W  = 4,
    parameter int LANES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_n,
    input  logic            irdy_n,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe_n,
    input  logic            par,
    input  logic            is_master,
    input  logic            cmd_serr_en,
    input  logic            cmd_par_resp_en,
    input  logic            sts_clr_det,
    input  logic            sts_clr_sig,
    output logic            serr_oe_n,
    output logic            devsel_suppress,
    output logic            sts_det_perr,
    output logic            sts_sig_serr
);
    import pci_apc_pkg::*;

    logic            addr_phase;
    logic            chk_q;
    logic [AD_W-1:0] ad_q;
    logic [BE_W-1:0] cbe_q;
    logic            par_err;
    logic            report;
    apc_rsp_t        rsp_d, rsp_q;

    pci_apc_capture #(.AD_W(AD_W), .BE_W(BE_W)) u_capture (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .is_master(is_master),
        .ad(ad), .cbe_n(cbe_n), .addr_phase(addr_phase), .chk_q(chk_q),
        .ad_q(ad_q), .cbe_q(cbe_q)
    );

    pci_apc_parity #(.AD_W(AD_W), .BE_W(BE_W), .LANES(LANES)) u_parity (
        .chk_q(chk_q), .ad_q(ad_q), .cbe_q(cbe_q), .par(par), .par_err(par_err)
    );

    always_comb begin
        report         = par_err && cmd_serr_en && cmd_par_resp_en;
        rsp_d.serr_n   = !report;
        if (report)
            rsp_d.suppress = 1'b1;
        else if (frame_n && irdy_n)
            rsp_d.suppress = 1'b0;
        else
            rsp_d.suppress = rsp_q.suppress;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '{serr_n: 1'b1, suppress: 1'b0};
        else        rsp_q <= rsp_d;
    end

    pci_apc_status u_status (
        .clk(clk), .rst_n(rst_n), .set_det(par_err), .set_sig(report),
        .clr_det(sts_clr_det), .clr_sig(sts_clr_sig),
        .det_q(sts_det_perr), .sig_q(sts_sig_serr)
    );

    assign serr_oe_n       = rsp_q.serr_n;
    assign devsel_suppress = rsp_q.suppress;

    AST_SERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !serr_oe_n |=> serr_oe_n); // R6
    AST_SERR_NEEDS_BOTH_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serr_oe_n) |-> $past(cmd_serr_en && cmd_par_resp_en)); // R6
    AST_SERR_TWO_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serr_oe_n) |-> $past(addr_phase, 2)); // R7
    AST_SERR_MARKS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serr_oe_n) |-> (sts_sig_serr && sts_det_perr)); // R8
    AST_SUPPRESS_WITH_SERR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(serr_oe_n) |-> devsel_suppress); // R11
    AST_SUPPRESS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_suppress && !(frame_n && irdy_n)) |=> devsel_suppress); // R11

endmodule

// File: tb/test_pci_addr_par_chk.sv
`timescale 1ns/1ps
module test_pci_addr_par_chk;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, par = 1'b0, is_master = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        cmd_serr_en = 1'b0, cmd_par_resp_en = 1'b0;
    logic        sts_clr_det = 1'b0, sts_clr_sig = 1'b0;
    logic        serr_oe_n, devsel_suppress, sts_det_perr, sts_sig_serr;

    int checks = 0;
    int errors = 0;
    logic good_par;

    always #10 clk = ~clk;

    pci_addr_par_chk i_pci_addr_par_chk (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .ad(ad),
        .cbe_n(cbe_n), .par(par), .is_master(is_master), .cmd_serr_en(cmd_serr_en),
        .cmd_par_resp_en(cmd_par_resp_en), .sts_clr_det(sts_clr_det),
        .sts_clr_sig(sts_clr_sig), .serr_oe_n(serr_oe_n),
        .devsel_suppress(devsel_suppress), .sts_det_perr(sts_det_perr),
        .sts_sig_serr(sts_sig_serr)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        sts_clr_det = 1'b1; sts_clr_sig = 1'b1;
        step();
        sts_clr_det = 1'b0; sts_clr_sig = 1'b0;
        frame_n = 1'b1; irdy_n = 1'b1;
        step();
    endtask

    // Address phase driven now; PAR follows. After return we sit just past E1.
    task automatic addr_cycle(input logic [31:0] a, input logic [3:0] c, input logic bad);
        frame_n = 1'b0; irdy_n = 1'b1; ad = a; cbe_n = c; par = 1'b0;
        good_par = ^{a, c};
        step();
        frame_n = 1'b1; irdy_n = 1'b0; ad = ~a; par = good_par ^ bad;
        step();
    endtask

    task automatic t_reset();
        chk("R1 serr", serr_oe_n, 1'b1);
        chk("R1 suppress", devsel_suppress, 1'b0);
        chk("R1 det", sts_det_perr, 1'b0);
        chk("R1 sig", sts_sig_serr, 1'b0);
    endtask

    task automatic t_good_parity();
        cmd_serr_en = 1'b1; cmd_par_resp_en = 1'b1;
        addr_cycle(32'h1234_5678, 4'h6, 1'b0);
        chk("R2 good det", sts_det_perr, 1'b0);
        chk("R2 good serr", serr_oe_n, 1'b1);
        addr_cycle(32'hFFFF_0001, 4'hB, 1'b0);
        chk("R2 good det2", sts_det_perr, 1'b0);
        clear_all();
    endtask

    task automatic t_bad_reported();
        cmd_serr_en = 1'b1; cmd_par_resp_en = 1'b1;
        addr_cycle(32'hA5A5_0F0F, 4'h7, 1'b1);
        chk("R2 R5 det", sts_det_perr, 1'b1);
        chk("R7 serr low", serr_oe_n, 1'b0);
        chk("R8 sig", sts_sig_serr, 1'b1);
        chk("R11 suppress on", devsel_suppress, 1'b1);
        step();
        chk("R6 serr one clock", serr_oe_n, 1'b1);
        chk("R11 suppress held", devsel_suppress, 1'b1);
        irdy_n = 1'b1;
        step();
        chk("R11 suppress off at idle", devsel_suppress, 1'b0);
        chk("R7 serr released", serr_oe_n, 1'b1);
        clear_all();
        chk("R9 det cleared", sts_det_perr, 1'b0);
        chk("R9 sig cleared", sts_sig_serr, 1'b0);
    endtask

    task automatic t_bad_partial_enable();
        cmd_serr_en = 1'b1; cmd_par_resp_en = 1'b0;
        addr_cycle(32'h0000_0003, 4'h2, 1'b1);
        chk("R5 det without response", sts_det_perr, 1'b1);
        chk("R6 no serr", serr_oe_n, 1'b1);
        chk("R11 no suppress", devsel_suppress, 1'b0);
        chk("R8 no sig", sts_sig_serr, 1'b0);
        clear_all();
        cmd_serr_en = 1'b0; cmd_par_resp_en = 1'b1;
        addr_cycle(32'h8000_0000, 4'hF, 1'b1);
        chk("R5 det serr disabled", sts_det_perr, 1'b1);
        chk("R6 no serr 2", serr_oe_n, 1'b1);
        clear_all();
    endtask

    task automatic t_master();
        cmd_serr_en = 1'b1; cmd_par_resp_en = 1'b1; is_master = 1'b1;
        addr_cycle(32'h5555_AAAA, 4'h1, 1'b1);
        chk("R4 master det", sts_det_perr, 1'b0);
        chk("R4 master serr", serr_oe_n, 1'b1);
        is_master = 1'b0;
        clear_all();
    endtask

    task automatic t_burst_no_recheck();
        cmd_serr_en = 1'b1; cmd_par_resp_en = 1'b1;
        frame_n = 1'b0; ad = 32'h0000_0010; cbe_n = 4'h7;
        good_par = ^{32'h0000_0010, 4'h7};
        step();
        irdy_n = 1'b0; par = good_par; ad = 32'h0000_0001; cbe_n = 4'h0;
        step();
        par = 1'b0;
        step();
        par = 1'b1; ad = 32'h0000_0003;
        step();
        chk("R3 data phases unchecked det", sts_det_perr, 1'b0);
        chk("R3 data phases unchecked serr", serr_oe_n, 1'b1);
        clear_all();
    endtask

    task automatic t_w1c();
        cmd_serr_en = 1'b1; cmd_par_resp_en = 1'b1;
        addr_cycle(32'h0F0F_0F0F, 4'h3, 1'b1);
        irdy_n = 1'b1; frame_n = 1'b1;
        step();
        step();
        chk("R9 holds without strobe", sts_det_perr, 1'b1);
        sts_clr_sig = 1'b1;
        step();
        sts_clr_sig = 1'b0;
        chk("R9 sig cleared alone", sts_sig_serr, 1'b0);
        chk("R9 det kept", sts_det_perr, 1'b1);
        clear_all();
    endtask

    task automatic t_set_wins();
        cmd_serr_en = 1'b1; cmd_par_resp_en = 1'b1;
        frame_n = 1'b0; irdy_n = 1'b1; ad = 32'h00FF_00FF; cbe_n = 4'hC;
        good_par = ^{32'h00FF_00FF, 4'hC};
        step();
        frame_n = 1'b1; irdy_n = 1'b0; par = ~good_par;
        sts_clr_det = 1'b1; sts_clr_sig = 1'b1;
        step();
        sts_clr_det = 1'b0; sts_clr_sig = 1'b0;
        chk("R10 det set wins", sts_det_perr, 1'b1);
        chk("R10 sig set wins", sts_sig_serr, 1'b1);
        clear_all();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_good_parity();
        t_bad_reported();
        t_bad_partial_enable();
        t_master();
        t_burst_no_recheck();
        t_w1c();
        t_set_wins();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule